// File: doc/BRIEF.md
# I2C Target Register Front End

This block is the serial-bus side of a small register bank. It watches an
oversampled two-wire bus (clock and data), finds the framing conditions, and
answers to one 7-bit bus address. The upper four bits of that address are a
fixed prefix of `0100`. The lower three bits come from strap pins. It drives
the data line only as an open-drain pull-down enable. Nothing else goes out on
the bus.

After the address byte, a bus write delivers a command byte. The block keeps
that byte as a sticky register pointer. Every data byte that follows in the
same write lands in the pointed register through a one-cycle write strobe. A
bus read returns the pointed register over and over, one byte per master
acknowledge. For each byte, a read strobe fires at the SCL falling edge that
opens the byte, so a register whose value is consumed on read (an input port
snapshot) can react. The pointer survives STOP and repeated START. A master
therefore selects a register with a short write, issues a repeated START, and
then reads it.

Both bus lines pass through a synchronizer on a system clock that runs at least
eight times faster than SCL. All framing decisions are made on the synchronized
edges.

Top module: `i2c_reg_slave`

## Requirements
- R1: While reset is asserted and right after it, `sda_oe`, `wr_stb` and `rd_stb` are 0 and `reg_addr` is 0.
- R2: A START (data falling while clock is high) at any point, including in the middle of a byte, drops the partial byte and restarts address reception. A STOP (data rising while clock is high) returns the block to idle. A byte cut short this way never causes a write.
- R3: The block acknowledges an address byte only when its upper seven bits equal `0100` followed by `dev_pins[2:0]` (MSB first). The acknowledge is `sda_oe`=1 held through the high phase of the ninth clock. On a mismatch it does not acknowledge, and it ignores all further bytes until the next START.
- R4: In a write (bit 0 of the address byte = 0), the first byte after the address is acknowledged and becomes `reg_addr`.
- R5: Each later byte in the same write is acknowledged and produces exactly one `wr_stb` pulse, with `wr_data` equal to that byte and `reg_addr` unchanged. The pointer does not advance.
- R6: In a read (bit 0 of the address byte = 1), the block sends `rd_data` for `reg_addr`, MSB first, with data 0 driven as `sda_oe`=1. `rd_data` is captured, and `rd_stb` pulses for one cycle, at the SCL falling edge that begins each byte, while SCL is low.
- R7: After a master acknowledge (data low on the ninth clock), a freshly captured byte follows. After a not-acknowledge, the block releases the data line and sends nothing more until the next START.
- R8: The pointer keeps its value across STOP and repeated START. A command write, then a repeated START, then a read address returns the chosen register.
- R9: `sda_oe` changes only while the synchronized SCL is low.
- R10: `wr_stb` and `rd_stb` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| dev_pins | input | 3 | Strap pins forming the low three address bits |
| reg_addr | output | 8 | Sticky register pointer toward the bank |
| wr_stb | output | 1 | One-cycle write strobe toward the bank |
| wr_data | output | 8 | Byte to write, valid with `wr_stb` |
| rd_stb | output | 1 | One-cycle read strobe, marks the capture of `rd_data` |
| rd_data | input | 8 | Bank contents at `reg_addr` |

## Verification
The hardest cases to reach are the ones where bus framing breaks off partway
through a byte. These are a START that lands after only a few bits of an
address or data byte, and a STOP in the middle of a data byte. The bench
produces them with a partial-byte task that clocks a chosen number of bits
before issuing START or STOP. It then proves at the ports that no write strobe
fired and that a fresh address is acknowledged. Repeated capture during reads
is made visible with a bench register that changes on every read strobe, so
each byte of a multi-byte read must carry a different value.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BCNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } frame_st_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_CMD,
    BK_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic [STAGES-1:0] scl_pipe_n, sda_pipe_n;
  logic scl_d, sda_d;

  // Idle bus level is high on both lines, so reset fills with ones.
  always_comb begin
    scl_pipe_n = {scl_pipe[STAGES-2:0], scl_i};
    sda_pipe_n = {sda_pipe[STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= scl_pipe_n;
      sda_pipe <= sda_pipe_n;
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_ptr_hold.sv
module i2c_ptr_hold
  import i2c_slv_pkg::*;
#(
  parameter int unsigned PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic [PTR_W-1:0]  ptr
);
  logic [PTR_W-1:0] ptr_q, ptr_n;

  always_comb begin
    ptr_n = ptr_q;
    if (load) ptr_n = din[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/i2c_frame_ctrl.sv
module i2c_frame_ctrl
  import i2c_slv_pkg::*;
#(
  parameter logic [3:0]  DEV_PREFIX = 4'b0100,
  parameter int unsigned PIN_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [PIN_W-1:0]  dev_pins,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_stb,
  output logic              cmd_load,
  output logic [BYTE_W-1:0] cmd_byte
);
  localparam logic [BCNT_W-1:0] CNT_FULL = BCNT_W'(BYTE_W);
  localparam logic [BCNT_W-1:0] CNT_LAST = BCNT_W'(BYTE_W - 1);

  frame_st_e         st_q, st_n;
  byte_kind_e        kind_q, kind_n;
  logic [BCNT_W-1:0] cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [BYTE_W-1:0] wd_q, wd_n;
  logic [BYTE_W-1:0] cmd_q, cmd_n;
  logic              rw_q, rw_n;
  logic              mack_q, mack_n;
  logic              oe_q, oe_n;
  logic              wr_q, wr_n;
  logic              rd_q, rd_n;
  logic              ld_q, ld_n;
  logic              tx_load;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == {DEV_PREFIX, dev_pins});

  always_comb begin
    st_n    = st_q;
    kind_n  = kind_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    wd_n    = wd_q;
    cmd_n   = cmd_q;
    rw_n    = rw_q;
    mack_n  = mack_q;
    oe_n    = oe_q;
    wr_n    = 1'b0;
    rd_n    = 1'b0;
    ld_n    = 1'b0;
    tx_load = 1'b0;

    if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_det) begin
      st_n   = ST_RX;
      kind_n = BK_ADDR;
      cnt_n  = '0;
      oe_n   = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && (cnt_q < CNT_FULL)) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == CNT_FULL)) begin
            unique case (kind_q)
              BK_ADDR: begin
                if (addr_hit) begin
                  oe_n = 1'b1;
                  rw_n = sh_q[0];
                  st_n = ST_RX_ACK;
                end else begin
                  st_n = ST_IDLE;
                end
              end
              BK_CMD: begin
                ld_n  = 1'b1;
                cmd_n = sh_q;
                oe_n  = 1'b1;
                st_n  = ST_RX_ACK;
              end
              default: begin
                wr_n = 1'b1;
                wd_n = sh_q;
                oe_n = 1'b1;
                st_n = ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            if ((kind_q == BK_ADDR) && rw_q) begin
              tx_load = 1'b1;
            end else begin
              st_n   = ST_RX;
              kind_n = (kind_q == BK_ADDR) ? BK_CMD : BK_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              oe_n = 1'b0;
              st_n = ST_TX_ACK;
            end else begin
              cnt_n = cnt_q + 1'b1;
              sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_n  = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack_n = ~sda_s;
          if (scl_fall) begin
            if (mack_q) tx_load = 1'b1;
            else        st_n    = ST_IDLE;
          end
        end
        default: ;
      endcase

      if (tx_load) begin
        st_n  = ST_TX;
        rd_n  = 1'b1;
        sh_n  = rd_data;
        oe_n  = ~rd_data[BYTE_W-1];
        cnt_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= BK_ADDR;
      cnt_q  <= '0;
      sh_q   <= '0;
      wd_q   <= '0;
      cmd_q  <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      ld_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      kind_q <= kind_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      wd_q   <= wd_n;
      cmd_q  <= cmd_n;
      rw_q   <= rw_n;
      mack_q <= mack_n;
      oe_q   <= oe_n;
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      ld_q   <= ld_n;
    end
  end

  assign sda_oe   = oe_q;
  assign wr_stb   = wr_q;
  assign wr_data  = wd_q;
  assign rd_stb   = rd_q;
  assign cmd_load = ld_q;
  assign cmd_byte = cmd_q;
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PTR_W       = 8,
  parameter logic [3:0]  DEV_PREFIX  = 4'b0100,
  parameter int unsigned PIN_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [PIN_W-1:0]  dev_pins,
  output logic [PTR_W-1:0]  reg_addr,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_stb,
  input  logic [BYTE_W-1:0] rd_data
);
  logic              scl_sync, sda_sync;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              cmd_load;
  logic [BYTE_W-1:0] cmd_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_sync),
    .sda_s     (sda_sync),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_frame_ctrl #(.DEV_PREFIX(DEV_PREFIX), .PIN_W(PIN_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_sync),
    .dev_pins  (dev_pins),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .rd_stb    (rd_stb),
    .cmd_load  (cmd_load),
    .cmd_byte  (cmd_byte)
  );

  i2c_ptr_hold #(.PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmd_load),
    .din   (cmd_byte),
    .ptr   (reg_addr)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int unsigned PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic [PTR_W-1:0] reg_addr
);
  // R9: the pull-down only engages while the synchronized clock is low
  p_oe_rise_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R10: strobes are exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb));

  // R10: write strobe lasts one cycle
  p_wr_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R6: read strobe lasts one cycle and occurs with the clock low
  p_rd_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);

  p_rd_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> !scl_s);

  // R5: a data write never moves the pointer
  p_ptr_hold_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $stable(reg_addr));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_sync),
  .sda_oe   (sda_oe),
  .wr_stb   (wr_stb),
  .rd_stb   (rd_stb),
  .reg_addr (reg_addr)
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int WDOG       = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] dev_pins = 3'b000;
  logic       sda_oe, wr_stb, rd_stb;
  logic [7:0] reg_addr, wr_data, rd_data;
  wire        sda_line = sda_m & ~sda_oe;

  int         n_vec = 0;
  int         n_bad = 0;
  int         wcnt = 0;
  int         rcnt = 0;
  int         pulse_bad = 0;
  int         oe_glitch = 0;
  logic       wr_prev = 1'b0;
  logic       rd_prev = 1'b0;
  logic [7:0] in_val = 8'hC0;
  logic       have_w = 1'b0;
  logic [7:0] last_wa = 8'h00;
  logic [7:0] last_wd = 8'h00;
  logic [7:0] w_addr [64];
  logic [7:0] w_data [64];
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_slave i_i2c_reg_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .dev_pins (dev_pins),
    .reg_addr (reg_addr),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data)
  );

  // Bench register bank: address 0 is an input snapshot that moves on each read.
  assign rd_data = (reg_addr == 8'h00) ? in_val :
                   (have_w && (reg_addr == last_wa)) ? last_wd :
                   8'(reg_addr * 8'd7 + 8'd3);

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        w_addr[wcnt % 64] <= reg_addr;
        w_data[wcnt % 64] <= wr_data;
        last_wa <= reg_addr;
        last_wd <= wr_data;
        have_w  <= 1'b1;
        wcnt    <= wcnt + 1;
      end
      if (rd_stb) begin
        rcnt <= rcnt + 1;
        if (reg_addr == 8'h00) in_val <= in_val + 8'd1;
      end
      if ((wr_stb && rd_stb) || (wr_stb && wr_prev) || (rd_stb && rd_prev))
        pulse_bad <= pulse_bad + 1;
      wr_prev <= wr_stb;
      rd_prev <= rd_stb;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    logic oe_mid;
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(Q);
    r      = sda_line;
    oe_mid = sda_oe;
    tick(Q);
    if (sda_oe !== oe_mid) oe_glitch++;
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_bits(input logic [7:0] v, input int n);
    logic r;
    for (int i = 7; i > 7 - n; i--) clk_bit(v[i], r);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      v[i] = r;
    end
    clk_bit(~give_ack, r);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] v;
    int         w0, r0;

    tick(4);
    chk("R1 sda_oe in reset", int'(sda_oe), 0);
    chk("R1 strobes in reset", int'({wr_stb, rd_stb}), 0);
    rst_n = 1'b1;
    tick(3);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 reg_addr after reset", int'(reg_addr), 0);
    chk("R1 strobes after reset", int'({wr_stb, rd_stb}), 0);

    // R3: every pin setting against every low-address pattern
    for (int p = 0; p < 8; p++) begin
      dev_pins = 3'(p);
      for (int t = 0; t < 8; t++) begin
        bus_start();
        put_byte({4'b0100, 3'(t), 1'b0}, ack);
        bus_stop();
        chk($sformatf("R3 ack pins=%0d low=%0d", p, t), int'(ack), int'(t == p));
      end
    end
    // R3: full 7-bit address sweep for one pin setting
    dev_pins = 3'b101;
    for (int a = 0; a < 128; a++) begin
      bus_start();
      put_byte({7'(a), 1'b0}, ack);
      bus_stop();
      chk($sformatf("R3 ack addr=%0h", a), int'(ack), int'(a == 7'h25));
    end

    dev_pins = 3'b010;
    // R3: mismatched address then a byte: no ack, no write, pointer kept
    w0 = wcnt;
    bus_start();
    put_byte(8'h46, ack);
    chk("R3 mismatch nack", int'(ack), 0);
    put_byte(8'h77, ack);
    chk("R3 later byte ignored", int'(ack), 0);
    bus_stop();
    chk("R3 no write on mismatch", wcnt - w0, 0);
    chk("R3 pointer untouched", int'(reg_addr), 0);

    // R4 / R5: command then three data bytes
    w0 = wcnt;
    bus_start();
    put_byte(8'h44, ack); chk("R4 address ack", int'(ack), 1);
    put_byte(8'h2A, ack); chk("R4 command ack", int'(ack), 1);
    tick(2);
    chk("R4 pointer loaded", int'(reg_addr), 'h2A);
    put_byte(8'h11, ack); chk("R5 data ack 1", int'(ack), 1);
    put_byte(8'h22, ack); chk("R5 data ack 2", int'(ack), 1);
    put_byte(8'h33, ack); chk("R5 data ack 3", int'(ack), 1);
    bus_stop();
    chk("R5 write count", wcnt - w0, 3);
    for (int k = 0; k < 3; k++) begin
      chk($sformatf("R5 write %0d addr", k), int'(w_addr[(w0 + k) % 64]), 'h2A);
      chk($sformatf("R5 write %0d data", k), int'(w_data[(w0 + k) % 64]), 'h11 * (k + 1));
    end
    chk("R5 pointer not advanced", int'(reg_addr), 'h2A);

    // R8 / R6 / R7: read after STOP keeps returning the same register
    r0 = rcnt;
    bus_start();
    put_byte(8'h45, ack); chk("R6 read address ack", int'(ack), 1);
    get_byte(1'b1, v);    chk("R8 sticky read 1", int'(v), 'h33);
    get_byte(1'b1, v);    chk("R8 sticky read 2", int'(v), 'h33);
    get_byte(1'b0, v);    chk("R7 read 3 before nack", int'(v), 'h33);
    chk("R6 one strobe per byte", rcnt - r0, 3);
    get_byte(1'b0, v);
    chk("R7 released after nack", int'(v), 'hFF);
    chk("R7 no capture after nack", rcnt - r0, 3);
    bus_stop();

    // R8: command, repeated START, read
    bus_start();
    put_byte(8'h44, ack);
    put_byte(8'h05, ack);
    bus_start();
    put_byte(8'h45, ack); chk("R8 repeated start ack", int'(ack), 1);
    get_byte(1'b0, v);    chk("R8 selected register", int'(v), 5 * 7 + 3);
    bus_stop();
    chk("R8 pointer after read", int'(reg_addr), 5);

    // R6 / R7: input snapshot recaptured for every byte and every transaction
    bus_start();
    put_byte(8'h44, ack);
    put_byte(8'h00, ack);
    bus_stop();
    for (int tr = 0; tr < 2; tr++) begin
      bus_start();
      put_byte(8'h45, ack);
      get_byte(1'b1, v); chk($sformatf("R7 snapshot t%0d b0", tr), int'(v), 'hC0 + 2 * tr);
      get_byte(1'b0, v); chk($sformatf("R6 snapshot t%0d b1", tr), int'(v), 'hC1 + 2 * tr);
      bus_stop();
    end

    // R2: START after part of a data byte
    w0 = wcnt;
    bus_start();
    put_byte(8'h44, ack);
    put_byte(8'h12, ack);
    put_bits(8'hF0, 4);
    bus_start();
    put_byte(8'h44, ack); chk("R2 address after mid-byte start", int'(ack), 1);
    bus_stop();
    chk("R2 no write from cut byte", wcnt - w0, 0);
    chk("R2 pointer from full command", int'(reg_addr), 'h12);

    // R2: START inside the address byte
    bus_start();
    put_bits(8'h44, 3);
    bus_start();
    put_byte(8'h44, ack); chk("R2 address after cut address", int'(ack), 1);
    put_byte(8'h3C, ack);
    bus_stop();
    chk("R2 command after restart", int'(reg_addr), 'h3C);

    // R2: STOP inside a data byte
    w0 = wcnt;
    bus_start();
    put_byte(8'h44, ack);
    put_byte(8'h19, ack);
    put_bits(8'hAA, 5);
    bus_stop();
    chk("R2 no write on mid-byte stop", wcnt - w0, 0);
    put_byte(8'h55, ack);
    chk("R2 idle after stop", int'(ack), 0);
    chk("R2 pointer after stop", int'(reg_addr), 'h19);

    chk("R9 sda_oe steady while clock high", oe_glitch, 0);
    chk("R10 strobe shape", pulse_bad, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule